// File: doc/BRIEF.md
# Programmable Logic Output Macrocell

This block is one output cell of a small sum-of-products programmable logic device. A group of product terms from the AND array arrives on `terms_i`; the cell ORs them, optionally inverts the sum, and either passes it straight to the pin or captures it in a D flip-flop on the shared clock. It also returns one signal to the AND array as feedback, and drives a tri-state enable for the pin.

Two global configuration bits, which every cell in the device shares, and one local bit per cell pick one of four behaviours: registered, combinatorial with a product-term enable, always-driven combinatorial, or input only. A separate bit sets the polarity. Cells at the two restricted pin positions, selected by the `RESTRICTED` parameter, cannot be input-only and return no feedback when always driven. The register clears on reset and can be loaded directly for test.

Top module: `pal_macrocell`

## Requirements
- R1: While `rst_ni` is low the register holds 0, so in registered behaviour `pin_o` and `fb_o` read 0 before any clock edge.
- R2: The sum is the OR of the data terms, and `inv_i`=1 inverts it before the pin (and before the register).
- R3: In registered behaviour `pin_o` takes, one rising clock edge later, the OR of all `terms_i` bits XOR `inv_i`, and `pin_oe_o` follows `oe_i`.
- R4: When `pl_en_i` is high at a rising edge, the register loads `pl_val_i` and ignores its normal data input.
- R5: In registered behaviour `fb_o` equals the register output.
- R6: In combinatorial I/O behaviour `terms_i[0]` is the pin enable, the sum uses only `terms_i[NUM_TERMS-1:1]`, and `fb_o` is the driven value when enabled, otherwise `pad_i`.
- R7: In always-driven combinatorial behaviour `pin_oe_o` is 1 and `fb_o` is the driven value, except at restricted positions where `fb_o` is 0.
- R8: In input-only behaviour `pin_oe_o` is 0, `pin_o` is 0 and `fb_o` equals `adj_i`.
- R9: At a restricted position a request for input-only behaviour gives always-driven combinatorial behaviour.
- R10: Decoding: `glb_mode_i`=2'b1x with `loc_i`=0 is registered, with `loc_i`=1 is combinatorial I/O; 2'b01 is combinatorial I/O whatever `loc_i`; 2'b00 with `loc_i`=0 is always-driven, with `loc_i`=1 is input-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared register clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| terms_i | input | NUM_TERMS | Product terms from the AND array |
| glb_mode_i | input | 2 | Device-wide configuration bits |
| loc_i | input | 1 | Per-cell configuration bit |
| inv_i | input | 1 | Output polarity (1 = inverted) |
| oe_i | input | 1 | Shared output-enable pin (active high) |
| pad_i | input | 1 | Value seen at this cell's pin |
| adj_i | input | 1 | Value seen at the neighbouring pin |
| pl_en_i | input | 1 | Register preload strobe |
| pl_val_i | input | 1 | Register preload value |
| pin_o | output | 1 | Value driven to the pin |
| pin_oe_o | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback to the AND array |

## Verification
The assertions assume the configuration bits are static during normal operation and that reset is released away from a clock edge; the stimulus changes configuration only at the falling edge and runs at least one full cycle in each behaviour. The preload and capture checks assume `pl_en_i` and `terms_i` are settled at the rising edge, which the bench guarantees by driving every input on the falling edge. The restricted-position property presumes the device is never configured into a behaviour the position lacks by any other means than the decoder.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;
  typedef enum logic [1:0] {
    MODE_REG  = 2'd0,
    MODE_CIO  = 2'd1,
    MODE_COUT = 2'd2,
    MODE_DIN  = 2'd3
  } mc_mode_e;
endpackage

// File: rtl/pal_mc_mode_dec.sv
module pal_mc_mode_dec
  import pal_mc_pkg::*;
#(
  parameter bit RESTRICTED = 1'b0
) (
  input  logic [1:0] glb_mode_i,
  input  logic       loc_i,
  output mc_mode_e   mode_o
);
  always_comb begin
    if (glb_mode_i[1]) begin
      mode_o = loc_i ? MODE_CIO : MODE_REG;
    end else if (glb_mode_i[0]) begin
      mode_o = MODE_CIO;
    end else if (loc_i && !RESTRICTED) begin
      mode_o = MODE_DIN;
    end else begin
      mode_o = MODE_COUT;
    end
  end
endmodule

// File: rtl/pal_mc_sum.sv
module pal_mc_sum #(
  parameter int NUM_TERMS = 8
) (
  input  logic [NUM_TERMS-1:0] terms_i,
  output logic                 sum_all_o,
  output logic                 sum_tail_o
);
  // acc[i] = OR of terms_i[NUM_TERMS-1:i]
  logic [NUM_TERMS:0] acc;
  assign acc[NUM_TERMS] = 1'b0;

  for (genvar i = 0; i < NUM_TERMS; i++) begin : g_or
    assign acc[i] = acc[i+1] | terms_i[i];
  end

  assign sum_all_o  = acc[0];
  assign sum_tail_o = acc[1];
endmodule

// File: rtl/pal_mc_reg.sv
module pal_mc_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic pl_en_i,
  input  logic pl_val_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (pl_en_i) q_o <= pl_val_i;
    else              q_o <= d_i;
  end

  assert_preload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_en_i |=> q_o == $past(pl_val_i));

  assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pl_en_i |=> q_o == $past(d_i));
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_mc_pkg::*;
#(
  parameter int NUM_TERMS  = 8,
  parameter bit RESTRICTED = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_TERMS-1:0] terms_i,
  input  logic [1:0]           glb_mode_i,
  input  logic                 loc_i,
  input  logic                 inv_i,
  input  logic                 oe_i,
  input  logic                 pad_i,
  input  logic                 adj_i,
  input  logic                 pl_en_i,
  input  logic                 pl_val_i,
  output logic                 pin_o,
  output logic                 pin_oe_o,
  output logic                 fb_o
);
  mc_mode_e mode_w;
  logic     sum_all, sum_tail, reg_d, reg_q, comb_val;

  pal_mc_mode_dec #(.RESTRICTED(RESTRICTED)) u_dec (
    .glb_mode_i(glb_mode_i),
    .loc_i     (loc_i),
    .mode_o    (mode_w)
  );

  pal_mc_sum #(.NUM_TERMS(NUM_TERMS)) u_sum (
    .terms_i   (terms_i),
    .sum_all_o (sum_all),
    .sum_tail_o(sum_tail)
  );

  assign reg_d = sum_all ^ inv_i;

  pal_mc_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (reg_d),
    .pl_en_i (pl_en_i),
    .pl_val_i(pl_val_i),
    .q_o     (reg_q)
  );

  // term 0 is taken for the enable in combinatorial I/O
  assign comb_val = ((mode_w == MODE_CIO) ? sum_tail : sum_all) ^ inv_i;

  always_comb begin
    unique case (mode_w)
      MODE_REG: begin
        pin_o    = reg_q;
        pin_oe_o = oe_i;
        fb_o     = reg_q;
      end
      MODE_CIO: begin
        pin_o    = comb_val;
        pin_oe_o = terms_i[0];
        fb_o     = terms_i[0] ? comb_val : pad_i;
      end
      MODE_COUT: begin
        pin_o    = comb_val;
        pin_oe_o = 1'b1;
        fb_o     = RESTRICTED ? 1'b0 : comb_val;
      end
      default: begin
        pin_o    = 1'b0;
        pin_oe_o = 1'b0;
        fb_o     = adj_i;
      end
    endcase
  end

  assert_dedin_hiz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w == MODE_DIN) |-> (!pin_oe_o && fb_o == adj_i));

  assert_cout_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w == MODE_COUT) |-> pin_oe_o);

  assert_reg_fb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w == MODE_REG) |-> (fb_o == reg_q && pin_o == reg_q));

  if (RESTRICTED) begin : g_restr_chk
    assert_no_dedin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_w != MODE_DIN);
  end
endmodule

// File: tb/tb_pal_macrocell.sv
`timescale 1ns/1ps
module tb_pal_macrocell;
  localparam int NT = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic [NT-1:0] terms_i = '0;
  logic [1:0]    glb_mode_i = 2'b10;
  logic          loc_i = 1'b0, inv_i = 1'b0, oe_i = 1'b1;
  logic          pad_i = 1'b0, adj_i = 1'b0, pl_en_i = 1'b0, pl_val_i = 1'b0;
  logic          pin_o, pin_oe_o, fb_o, e_pin, e_oe, e_fb;

  int errors = 0, checks = 0;
  logic model_q = 1'b0;

  typedef struct {
    logic [2:0] exp_n;
    logic [2:0] exp_e;
    string      tag;
  } item_t;
  item_t sb_q[$];
  event  pushed;

  always #2.5 clk_i = ~clk_i;

  pal_macrocell #(.NUM_TERMS(NT), .RESTRICTED(1'b0)) dut (
    .clk_i, .rst_ni, .terms_i, .glb_mode_i, .loc_i, .inv_i, .oe_i, .pad_i,
    .adj_i, .pl_en_i, .pl_val_i, .pin_o, .pin_oe_o, .fb_o);

  pal_macrocell #(.NUM_TERMS(NT), .RESTRICTED(1'b1)) dut_edge (
    .clk_i, .rst_ni, .terms_i, .glb_mode_i, .loc_i, .inv_i, .oe_i, .pad_i,
    .adj_i, .pl_en_i, .pl_val_i, .pin_o(e_pin), .pin_oe_o(e_oe), .fb_o(e_fb));

  // expected {pin, oe, fb} from the requirements
  function automatic logic [2:0] model(input bit restr);
    logic v;
    if (glb_mode_i[1] && !loc_i) return {model_q, oe_i, model_q};
    if (glb_mode_i[1] || glb_mode_i[0]) begin
      v = (|terms_i[NT-1:1]) ^ inv_i;
      return {v, terms_i[0], terms_i[0] ? v : pad_i};
    end
    if (loc_i && !restr) return {1'b0, 1'b0, adj_i};
    v = (|terms_i) ^ inv_i;
    return {v, 1'b1, restr ? 1'b0 : v};
  endfunction

  task automatic check3(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual={pin,oe,fb}=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: apply inputs at negedge, clock once, push expectation
  task automatic step(input string tag);
    item_t it;
    @(posedge clk_i);
    model_q = pl_en_i ? pl_val_i : ((|terms_i) ^ inv_i);
    #1;
    it.exp_n = model(1'b0);
    it.exp_e = model(1'b1);
    it.tag   = tag;
    sb_q.push_back(it);
    ->pushed;
    @(negedge clk_i);
  endtask

  // monitor
  initial begin
    forever begin
      @(pushed);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check3({pin_o, pin_oe_o, fb_o}, it.exp_n, {it.tag, " main"});
        check3({e_pin, e_oe, e_fb}, it.exp_e, {it.tag, " edge"});
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    terms_i = 8'hFF;
    #7;
    check3({pin_o, pin_oe_o, fb_o}, 3'b010, "R1 reset held");
    @(negedge clk_i);
    rst_ni = 1'b1;
    #0.5;
    check3({pin_o, pin_oe_o, fb_o}, 3'b010, "R1 after release");
    model_q = 1'b0;

    // registered
    terms_i = 8'h01; step("R3 capture one");
    terms_i = 8'h00; inv_i = 1'b1; step("R2 inverted zero");
    terms_i = 8'h80; step("R2 inverted term7");
    oe_i = 1'b0; terms_i = 8'h00; step("R3 oe follows pin");
    oe_i = 1'b1; step("R5 feedback is q");
    // preload
    inv_i = 1'b0; terms_i = 8'h10; pl_en_i = 1'b1; pl_val_i = 1'b0; step("R4 preload zero over one");
    terms_i = 8'h00; pl_val_i = 1'b1; step("R4 preload one over zero");
    pl_en_i = 1'b0; step("R3 normal after preload");

    // combinatorial I/O
    glb_mode_i = 2'b01; loc_i = 1'b0;
    terms_i = 8'h03; step("R6 enabled data");
    terms_i = 8'h01; step("R6 term0 excluded");
    terms_i = 8'h02; pad_i = 1'b1; step("R6 disabled pad fb");
    loc_i = 1'b1; pad_i = 1'b0; inv_i = 1'b1; step("R10 complex ignores local");
    glb_mode_i = 2'b10; terms_i = 8'h41; inv_i = 1'b0; step("R10 reg family local=1");

    // always driven
    glb_mode_i = 2'b00; loc_i = 1'b0;
    terms_i = 8'h20; step("R7 driven one");
    terms_i = 8'h00; inv_i = 1'b1; step("R7 driven inverted");

    // input only / restricted fallback
    loc_i = 1'b1; inv_i = 1'b0; terms_i = 8'h04; adj_i = 1'b1; step("R8 input adj one");
    adj_i = 1'b0; step("R9 input adj zero");
    terms_i = 8'h00; adj_i = 1'b1; step("R8 R9 no terms");

    repeat (2) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule